// File: doc/BRIEF.md
# Automatic Sliding Door Controller

This block decides how an automatic sliding door moves. It holds one of four states: shut, opening, fully open and closing. It watches a group of presence sensors, a lock switch, two travel-limit switches and an obstruction input. From these it commands the motor to open or to close, and it raises an alert when someone is at a locked door. The presence sensors are OR-ed into a single presence term, and the transition logic reuses that term.

The drive and alert outputs are combinational functions of the current state and the inputs. The open drive follows the open limit while the door is opening. The close drive follows the shut limit while the door is closing. The alert is raised only at a locked, shut door that sees presence. The state lives in a two-bit register. The reset is asynchronous and active-low, and its release is synchronised to the clock. Motor electronics, sensor filtering and hold-open timing belong to neighbouring blocks.

Top module: `door_ctrl`

## Requirements
- R1: While reset is held, and after it is released with no activity, the state output reads shut (2'b00) and all three command outputs are 0. The state encoding is shut=00, opening=01, fully open=11, closing=10. Asserting reset at any time returns the state to shut at once.
- R2: In shut, with presence and the lock input high, the alert output is 1 and the state stays shut. With the lock high and no presence, the alert is 0.
- R3: In shut, with presence and the lock low, the state becomes opening on the next clock edge. Without presence the state stays shut.
- R4: In opening, the open drive equals the inverse of the open limit. The state moves to fully open on the first edge where the open limit is 1, and otherwise it stays in opening.
- R5: In fully open, the state stays while presence or the obstruction input is high. It moves to closing when both are low. No command output is asserted in this state.
- R6: In closing, the close drive equals the inverse of the shut limit.
- R7: In closing, presence or obstruction sends the state back to opening on the next edge, even when the shut limit is 1.
- R8: In closing, with the shut limit high and neither presence nor obstruction, the state moves to shut. With the shut limit low it stays in closing.
- R9: The open drive and the close drive are never 1 in the same cycle. The alert is 0 outside the shut state.
- R10: Each presence sensor bit alone is enough to count as presence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| presence | input | N_SENSE | Presence sensor bits, any one high means presence |
| lock | input | 1 | Door locked |
| shut_limit | input | 1 | Door fully closed limit switch |
| open_limit | input | 1 | Door fully open limit switch |
| obstruct | input | 1 | Something in the doorway |
| drive_open | output | 1 | Command to move the door open |
| drive_close | output | 1 | Command to move the door closed |
| alert | output | 1 | Presence at a locked door |
| door_state | output | 2 | Current state code |

## Verification
A table of vectors takes the door through full cycles. Presence arrives once on each sensor bit, so each bit is shown to count alone. The lock is tried both with and without presence, which separates the alert condition from the opening condition. The limit switches are toggled inside opening and closing, which shows that the drives follow the limits while the state is held. Obstruction and presence are then raised in closing, once with the shut limit low and once with it high, which shows that reopening takes priority over finishing the close. A directed test asserts reset in the middle of an opening.

// File: rtl/door_pkg.sv
package door_pkg;
  typedef enum logic [1:0] {
    ST_SHUT    = 2'b00,
    ST_OPENING = 2'b01,
    ST_OPEN    = 2'b11,
    ST_CLOSING = 2'b10
  } door_state_e;
endpackage

// File: rtl/door_rst_sync.sv
module door_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/door_next_state.sv
module door_next_state
  import door_pkg::*;
(
  input  door_state_e cur,
  input  logic        anyone,
  input  logic        lock,
  input  logic        shut_limit,
  input  logic        open_limit,
  input  logic        obstruct,
  output door_state_e nxt
);
  always_comb begin
    nxt = cur;
    unique case (cur)
      ST_SHUT:    if (anyone && !lock) nxt = ST_OPENING;
      ST_OPENING: if (open_limit) nxt = ST_OPEN;
      ST_OPEN:    if (!anyone && !obstruct) nxt = ST_CLOSING;
      ST_CLOSING: begin
        if (anyone || obstruct) nxt = ST_OPENING;
        else if (shut_limit)    nxt = ST_SHUT;
      end
      default:    nxt = ST_SHUT;
    endcase
  end
endmodule

// File: rtl/door_out_dec.sv
module door_out_dec
  import door_pkg::*;
(
  input  door_state_e cur,
  input  logic        anyone,
  input  logic        lock,
  input  logic        shut_limit,
  input  logic        open_limit,
  output logic        drive_open,
  output logic        drive_close,
  output logic        alert
);
  always_comb begin
    drive_open  = 1'b0;
    drive_close = 1'b0;
    alert       = 1'b0;
    unique case (cur)
      ST_SHUT:    alert       = lock && anyone;
      ST_OPENING: drive_open  = !open_limit;
      ST_CLOSING: drive_close = !shut_limit;
      default:    ;
    endcase
  end
endmodule

// File: rtl/door_ctrl.sv
module door_ctrl
  import door_pkg::*;
#(
  parameter int N_SENSE     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_SENSE-1:0] presence,
  input  logic               lock,
  input  logic               shut_limit,
  input  logic               open_limit,
  input  logic               obstruct,
  output logic               drive_open,
  output logic               drive_close,
  output logic               alert,
  output logic [1:0]         door_state
);
  logic        rst_sync_n;
  logic        anyone;
  logic        state_en;
  door_state_e state_q;
  door_state_e state_d;

  door_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // one shared presence term for every transition that needs it
  assign anyone = |presence;

  door_next_state u_ns (
    .cur        (state_q),
    .anyone     (anyone),
    .lock       (lock),
    .shut_limit (shut_limit),
    .open_limit (open_limit),
    .obstruct   (obstruct),
    .nxt        (state_d)
  );

  assign state_en = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   state_q <= ST_SHUT;
    else if (state_en) state_q <= state_d;
  end

  door_out_dec u_out (
    .cur         (state_q),
    .anyone      (anyone),
    .lock        (lock),
    .shut_limit  (shut_limit),
    .open_limit  (open_limit),
    .drive_open  (drive_open),
    .drive_close (drive_close),
    .alert       (alert)
  );

  assign door_state = state_q;
endmodule

// File: rtl/door_ctrl_chk.sv
module door_ctrl_chk #(
  parameter int N_SENSE = 3
) (
  input logic               clk,
  input logic               rst_ok,
  input logic [N_SENSE-1:0] presence,
  input logic               lock,
  input logic               shut_limit,
  input logic               open_limit,
  input logic               obstruct,
  input logic               drive_open,
  input logic               drive_close,
  input logic               alert,
  input logic [1:0]         door_state
);
  assert_drives_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    !(drive_open && drive_close));

  assert_alert_only_shut_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    alert |-> door_state == 2'b00);

  assert_locked_holds_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    (door_state == 2'b00 && lock && |presence) |-> alert ##1 door_state == 2'b00);

  assert_start_open_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    (door_state == 2'b00 && !lock && |presence) |=> door_state == 2'b01);

  assert_reach_open_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    (door_state == 2'b01 && open_limit) |=> door_state == 2'b11);

  assert_begin_close_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    (door_state == 2'b11 && !(|presence) && !obstruct) |=> door_state == 2'b10);

  assert_close_drive_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    (door_state == 2'b10 && !shut_limit) |-> drive_close);

  assert_reopen_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    (door_state == 2'b10 && (|presence || obstruct)) |=> door_state == 2'b01);

  assert_finish_close_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    (door_state == 2'b10 && shut_limit && !(|presence) && !obstruct) |=> door_state == 2'b00);
endmodule

bind door_ctrl door_ctrl_chk #(.N_SENSE(N_SENSE)) u_chk (
  .clk         (clk),
  .rst_ok      (rst_sync_n),
  .presence    (presence),
  .lock        (lock),
  .shut_limit  (shut_limit),
  .open_limit  (open_limit),
  .obstruct    (obstruct),
  .drive_open  (drive_open),
  .drive_close (drive_close),
  .alert       (alert),
  .door_state  (door_state)
);

// File: tb/tb_door_ctrl.sv
module tb_door_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] presence;
  logic       lock, shut_limit, open_limit, obstruct;
  logic       drive_open, drive_close, alert;
  logic [1:0] door_state;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  door_ctrl dut (
    .clk(clk), .rst_n(rst_n), .presence(presence), .lock(lock),
    .shut_limit(shut_limit), .open_limit(open_limit), .obstruct(obstruct),
    .drive_open(drive_open), .drive_close(drive_close), .alert(alert),
    .door_state(door_state)
  );

  // {presence[2:0], lock, shut_limit, open_limit, obstruct, state[1:0], od, cd, bt}
  localparam int NV = 23;
  localparam logic [11:0] VEC [NV] = '{
    12'b000_0_1_0_0_00_000, // R3 no presence, stay shut
    12'b001_1_1_0_0_00_001, // R2 R10 locked with sensor 0
    12'b100_1_1_0_0_00_001, // R2 R10 locked with sensor 2
    12'b000_1_1_0_0_00_000, // R2 lock, nobody
    12'b010_0_1_0_0_00_000, // R3 R10 sensor 1 unlocked
    12'b010_0_0_0_0_01_100, // R4 opening
    12'b000_0_0_0_0_01_100, // R4 keeps opening without presence
    12'b000_0_0_1_0_01_000, // R4 open limit reached
    12'b000_0_0_1_1_11_000, // R5 obstruction holds
    12'b001_0_0_1_0_11_000, // R5 presence holds
    12'b000_0_0_1_0_11_000, // R5 idle, go closing
    12'b000_0_0_0_0_10_010, // R6 closing
    12'b000_0_0_0_1_10_010, // R7 obstruction reopens
    12'b000_0_0_0_0_01_100, // R7 back in opening
    12'b000_0_0_1_0_01_000, // R4
    12'b000_0_0_1_0_11_000, // R5
    12'b100_0_1_0_0_10_000, // R6 R7 presence beats shut limit
    12'b000_0_0_1_0_01_000, // R7 reopened
    12'b000_0_0_0_0_11_000, // R5
    12'b000_0_0_0_0_10_010, // R8 shut limit low stays
    12'b000_0_1_0_0_10_000, // R8 shut limit high, done
    12'b001_0_1_0_0_00_000, // R8 back in shut
    12'b000_0_0_0_0_01_100  // R3 opened again
  };

  task automatic check(input string req, input logic [4:0] exp_v);
    logic [4:0] act;
    act = {door_state, drive_open, drive_close, alert};
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s state/od/cd/bt actual %b expected %b", req, act, exp_v);
    end
    checks++;
    if (drive_open && drive_close) begin
      errors++;
      $display("FAIL R9 both drives actual 11 expected not 11");
    end
  endtask

  initial begin
    rst_n = 1'b0; presence = '0; lock = 0; shut_limit = 1; open_limit = 0; obstruct = 0;
    repeat (3) @(negedge clk);
    check("R1", 5'b00_000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", 5'b00_000);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {presence, lock, shut_limit, open_limit, obstruct} = VEC[i][11:5];
      #2;
      check($sformatf("R1-R10 row %0d", i), VEC[i][4:0]);
    end
    // directed: reset during opening clears state at once (R1)
    @(negedge clk);
    {presence, lock, shut_limit, open_limit, obstruct} = 7'b000_0_0_0_0;
    #2;
    check("R4 before reset", 5'b01_100);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", 5'b00_000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    presence = 3'b001;
    #2;
    check("R3 after reset", 5'b00_000);
    @(negedge clk);
    presence = '0;
    #2;
    check("R3 after reset", 5'b01_100);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule